// File: doc/BRIEF.md
# CAN Transceiver Mode Sequencer

This block drives the two mode-select pins of an external CAN-FD transceiver and times every change of mode. A caller asks for one of four modes on a valid/ready port. The block applies the matching pin pair and then holds itself busy for a fixed settle period. Only after that period does it report ready again. Entering sleep carries an extra wait before the pins move.

Two fixed sequences order the protocol controller's start and stop strobes against the pin changes:

- **Power-up initialization.** The pins go to sleep, then controller start is strobed, then the pins go to normal. After a long hold, the transceiver's active-low fault line is sampled once. A low fault line ends in a failed state. A high fault line ends in the operational state.
- **Bus-off recovery.** Controller stop is strobed and the transceiver is parked in standby through a long bus-idle gap. Then the pins return to normal and controller start is strobed again.

All delays count whole milliseconds. The clock frequency parameter sets how many clock cycles make one millisecond. Each delay's length in milliseconds is its own parameter.

Top module: `xcvr_mode_seq`

## Requirements
- R1: The 2-bit mode code sets the pins {stb,en} as follows: code 0 (sleep) gives stb=0,en=1; code 1 (standby) gives 0,0; code 2 (listen-only) gives 1,0; code 3 (normal) gives 1,1.
- R2: After reset the pins hold the standby pair (0,0), and link_ready, busy, init_fail, ctrl_start, ctrl_stop and req_ready are all low until an init is triggered.
- R3: When the target mode is sleep, the pins change no sooner than PRE_SLEEP_MS milliseconds after the request is taken, and at most 4 cycles after that. Any other target changes the pins within 4 cycles.
- R4: After every pin update, link_ready stays low and busy stays high for SETTLE_MS milliseconds (up to 4 cycles longer) before link_ready rises.
- R5: req_ready is high only while link_ready is high and neither bus_off nor init_start is asserted. A request offered while req_ready is low does not change the pins.
- R6: On init_start the pins go to sleep. ctrl_start pulses SETTLE_MS+INIT_GAP_MS ms after that pin change. The pins go to normal within 4 cycles of the pulse.
- R7: INIT_READY_MS ms after the normal settle, xcvr_fault_n is sampled. A low level raises init_fail and leaves link_ready low. A high level raises link_ready. A later init_start is accepted from the failed state.
- R8: On bus_off, ctrl_stop pulses first and the pins go to standby. The pins return to normal SETTLE_MS+BUSOFF_IDLE_MS ms after the standby change. ctrl_start pulses SETTLE_MS ms after the normal change.
- R9: When bus_off and a mode request arrive in the same cycle, the request is refused and recovery runs instead.
- R10: ctrl_start and ctrl_stop are single-cycle pulses and are never high together.
- R11: busy and link_ready are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Mode request offered |
| req_mode | input | 2 | Requested mode code (0 sleep, 1 standby, 2 listen, 3 normal) |
| req_ready | output | 1 | Request taken on this edge when valid is also high |
| init_start | input | 1 | Start the power-up sequence |
| bus_off | input | 1 | Bus-off event from the protocol controller |
| ctrl_start | output | 1 | One-cycle start strobe to the protocol controller |
| ctrl_stop | output | 1 | One-cycle stop strobe to the protocol controller |
| xcvr_stb | output | 1 | Transceiver standby-select pin |
| xcvr_en | output | 1 | Transceiver enable pin |
| xcvr_fault_n | input | 1 | Transceiver fault, low active |
| busy | output | 1 | A sequence, wait or settle period is running |
| link_ready | output | 1 | Operational and idle |
| init_fail | output | 1 | Last init sampled a fault |

## Verification
A wrong step in the sequencing state shows up first on the pin pair or the controller strobes. Examples are a skipped pre-sleep wait, the wrong next step after a wait, or a wrong target mode. Such an error appears within a few cycles of the point where the correct sequence would move: the pins change too early, show the wrong pair, or a strobe appears in the wrong order. A wrong delay count shows as link_ready or a strobe arriving a whole number of milliseconds off. A corrupted pending bus-off flag shows either as a request accepted in the same cycle as bus_off, or as a recovery that never begins.

// File: rtl/xms_pkg.sv
package xms_pkg;

    typedef enum logic [1:0] {
        XM_SLEEP   = 2'd0,
        XM_STANDBY = 2'd1,
        XM_LISTEN  = 2'd2,
        XM_NORMAL  = 2'd3
    } xmode_e;

    typedef struct packed {
        logic stb;
        logic en;
    } pin_pair_t;

    typedef enum logic [3:0] {
        ST_OFF,
        ST_IDLE,
        ST_FAILED,
        ST_PRE,
        ST_APPLY,
        ST_SETTLE,
        ST_WAIT,
        ST_START,
        ST_STOP,
        ST_CHECK
    } seq_state_e;

    typedef enum logic [2:0] {
        STP_USER,
        STP_INIT_SLEEP,
        STP_INIT_GAP,
        STP_INIT_NORMAL,
        STP_INIT_HOLD,
        STP_BO_STANDBY,
        STP_BO_IDLE,
        STP_BO_NORMAL
    } seq_step_e;

    function automatic pin_pair_t mode_pins(xmode_e m);
        pin_pair_t p;
        case (m)
            XM_SLEEP:   p = '{stb: 1'b0, en: 1'b1};
            XM_STANDBY: p = '{stb: 1'b0, en: 1'b0};
            XM_LISTEN:  p = '{stb: 1'b1, en: 1'b0};
            default:    p = '{stb: 1'b1, en: 1'b1};
        endcase
        return p;
    endfunction

    function automatic int max2(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/xms_tick_gen.sv
module xms_tick_gen #(
    parameter int TICK_CYCLES = 125000
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic en,
    output logic tick
);
    localparam int CW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_CYCLES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (en) begin
            if (cnt == LAST) cnt <= '0;
            else             cnt <= cnt + 1'b1;
        end
    end

    assign tick = en && (cnt == LAST);
endmodule

// File: rtl/xms_delay.sv
module xms_delay #(
    parameter int TICK_CYCLES = 125000,
    parameter int MS_W        = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic [MS_W-1:0] load_ms,
    output logic            done
);
    logic            running;
    logic [MS_W-1:0] ms_left;
    logic            tick;

    xms_tick_gen #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .clr  (load),
        .en   (running),
        .tick (tick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            running <= 1'b0;
            ms_left <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (load) begin
                if (load_ms == '0) begin
                    done    <= 1'b1;
                    running <= 1'b0;
                end else begin
                    ms_left <= load_ms;
                    running <= 1'b1;
                end
            end else if (running && tick) begin
                if (ms_left == MS_W'(1)) begin
                    done    <= 1'b1;
                    running <= 1'b0;
                end else begin
                    ms_left <= ms_left - 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/xms_fsm.sv
module xms_fsm
    import xms_pkg::*;
#(
    parameter int MS_W           = 8,
    parameter int PRE_SLEEP_MS   = 1,
    parameter int SETTLE_MS      = 10,
    parameter int INIT_GAP_MS    = 2,
    parameter int INIT_READY_MS  = 50,
    parameter int BUSOFF_IDLE_MS = 100
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req_valid,
    input  logic [1:0]      req_mode,
    input  logic            init_start,
    input  logic            bus_off,
    input  logic            fault_n,
    input  logic            t_done,
    output logic            t_load,
    output logic [MS_W-1:0] t_ms,
    output logic            req_ready,
    output logic            ctrl_start,
    output logic            ctrl_stop,
    output pin_pair_t       pins,
    output logic            busy,
    output logic            link_ready,
    output logic            init_fail
);
    seq_state_e state, state_n;
    seq_step_e  step,  step_n;
    xmode_e     tgt,   tgt_n;
    logic       bo_pend;
    logic       init_go;

    always_comb begin
        state_n = state;
        step_n  = step;
        tgt_n   = tgt;
        t_load  = 1'b0;
        t_ms    = '0;
        init_go = 1'b0;
        case (state)
            ST_OFF, ST_FAILED: begin
                if (init_start) init_go = 1'b1;
            end
            ST_IDLE: begin
                if (bus_off || bo_pend) begin
                    state_n = ST_STOP;
                end else if (init_start) begin
                    init_go = 1'b1;
                end else if (req_valid) begin
                    tgt_n   = xmode_e'(req_mode);
                    step_n  = STP_USER;
                    state_n = ST_APPLY;
                end
            end
            ST_STOP: begin
                tgt_n   = XM_STANDBY;
                step_n  = STP_BO_STANDBY;
                state_n = ST_APPLY;
            end
            ST_PRE: begin
                if (t_done) state_n = ST_APPLY;
            end
            ST_APPLY: begin
                t_load  = 1'b1;
                t_ms    = MS_W'(SETTLE_MS);
                state_n = ST_SETTLE;
            end
            ST_SETTLE: begin
                if (t_done) begin
                    case (step)
                        STP_INIT_SLEEP: begin
                            t_load  = 1'b1;
                            t_ms    = MS_W'(INIT_GAP_MS);
                            step_n  = STP_INIT_GAP;
                            state_n = ST_WAIT;
                        end
                        STP_INIT_NORMAL: begin
                            t_load  = 1'b1;
                            t_ms    = MS_W'(INIT_READY_MS);
                            step_n  = STP_INIT_HOLD;
                            state_n = ST_WAIT;
                        end
                        STP_BO_STANDBY: begin
                            t_load  = 1'b1;
                            t_ms    = MS_W'(BUSOFF_IDLE_MS);
                            step_n  = STP_BO_IDLE;
                            state_n = ST_WAIT;
                        end
                        STP_BO_NORMAL: state_n = ST_START;
                        default:       state_n = ST_IDLE;
                    endcase
                end
            end
            ST_WAIT: begin
                if (t_done) begin
                    case (step)
                        STP_INIT_GAP:  state_n = ST_START;
                        STP_INIT_HOLD: state_n = ST_CHECK;
                        STP_BO_IDLE: begin
                            tgt_n   = XM_NORMAL;
                            step_n  = STP_BO_NORMAL;
                            state_n = ST_APPLY;
                        end
                        default:       state_n = ST_IDLE;
                    endcase
                end
            end
            ST_START: begin
                if (step == STP_INIT_GAP) begin
                    tgt_n   = XM_NORMAL;
                    step_n  = STP_INIT_NORMAL;
                    state_n = ST_APPLY;
                end else begin
                    state_n = ST_IDLE;
                end
            end
            ST_CHECK: state_n = fault_n ? ST_IDLE : ST_FAILED;
            default:  state_n = ST_OFF;
        endcase
        if (init_go) begin
            tgt_n   = XM_SLEEP;
            step_n  = STP_INIT_SLEEP;
            state_n = ST_APPLY;
        end
        // entering sleep inserts the pre-transition wait ahead of the pin write
        if (state_n == ST_APPLY && state != ST_PRE && tgt_n == XM_SLEEP) begin
            state_n = ST_PRE;
            t_load  = 1'b1;
            t_ms    = MS_W'(PRE_SLEEP_MS);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_OFF;
            step      <= STP_USER;
            tgt       <= XM_STANDBY;
            pins      <= mode_pins(XM_STANDBY);
            init_fail <= 1'b0;
            bo_pend   <= 1'b0;
        end else begin
            state <= state_n;
            step  <= step_n;
            tgt   <= tgt_n;
            if (state == ST_APPLY) pins <= mode_pins(tgt);
            if (init_go)
                init_fail <= 1'b0;
            else if (state == ST_CHECK && !fault_n)
                init_fail <= 1'b1;
            if (state_n == ST_STOP || state_n == ST_FAILED)
                bo_pend <= 1'b0;
            else if (bus_off && state != ST_OFF && state != ST_FAILED)
                bo_pend <= 1'b1;
        end
    end

    assign ctrl_start = (state == ST_START);
    assign ctrl_stop  = (state == ST_STOP);
    assign link_ready = (state == ST_IDLE);
    assign busy       = !(state == ST_OFF || state == ST_IDLE || state == ST_FAILED);
    assign req_ready  = (state == ST_IDLE) && !bus_off && !bo_pend && !init_start;
endmodule

// File: rtl/xcvr_mode_seq.sv
module xcvr_mode_seq
    import xms_pkg::*;
#(
    parameter int CLK_HZ         = 125_000_000,
    parameter int PRE_SLEEP_MS   = 1,
    parameter int SETTLE_MS      = 10,
    parameter int INIT_GAP_MS    = 2,
    parameter int INIT_READY_MS  = 50,
    parameter int BUSOFF_IDLE_MS = 100
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    input  logic [1:0] req_mode,
    output logic       req_ready,
    input  logic       init_start,
    input  logic       bus_off,
    output logic       ctrl_start,
    output logic       ctrl_stop,
    output logic       xcvr_stb,
    output logic       xcvr_en,
    input  logic       xcvr_fault_n,
    output logic       busy,
    output logic       link_ready,
    output logic       init_fail
);
    localparam int TICK_CYCLES = (CLK_HZ >= 2000) ? (CLK_HZ / 1000) : 1;
    localparam int MAX_MS = max2(max2(max2(PRE_SLEEP_MS, SETTLE_MS),
                                      max2(INIT_GAP_MS, INIT_READY_MS)),
                                 BUSOFF_IDLE_MS);
    localparam int MS_W = $clog2(MAX_MS + 1) + 1;

    logic            t_load;
    logic [MS_W-1:0] t_ms;
    logic            t_done;
    pin_pair_t       pins;

    xms_delay #(.TICK_CYCLES(TICK_CYCLES), .MS_W(MS_W)) u_delay (
        .clk     (clk),
        .rst     (rst),
        .load    (t_load),
        .load_ms (t_ms),
        .done    (t_done)
    );

    xms_fsm #(
        .MS_W           (MS_W),
        .PRE_SLEEP_MS   (PRE_SLEEP_MS),
        .SETTLE_MS      (SETTLE_MS),
        .INIT_GAP_MS    (INIT_GAP_MS),
        .INIT_READY_MS  (INIT_READY_MS),
        .BUSOFF_IDLE_MS (BUSOFF_IDLE_MS)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_mode   (req_mode),
        .init_start (init_start),
        .bus_off    (bus_off),
        .fault_n    (xcvr_fault_n),
        .t_done     (t_done),
        .t_load     (t_load),
        .t_ms       (t_ms),
        .req_ready  (req_ready),
        .ctrl_start (ctrl_start),
        .ctrl_stop  (ctrl_stop),
        .pins       (pins),
        .busy       (busy),
        .link_ready (link_ready),
        .init_fail  (init_fail)
    );

    assign xcvr_stb = pins.stb;
    assign xcvr_en  = pins.en;
endmodule

// File: rtl/xms_checker.sv
module xms_checker (
    input logic clk,
    input logic rst,
    input logic req_ready,
    input logic ctrl_start,
    input logic ctrl_stop,
    input logic xcvr_stb,
    input logic xcvr_en,
    input logic busy,
    input logic link_ready,
    input logic init_fail
);
    AST_START_PULSE: assert property (@(posedge clk) disable iff (rst)
        ctrl_start |=> !ctrl_start);                                   // R10
    AST_STOP_PULSE: assert property (@(posedge clk) disable iff (rst)
        ctrl_stop |=> !ctrl_stop);                                     // R10
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(ctrl_start && ctrl_stop));                                   // R10
    AST_BUSY_READY_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(busy && link_ready));                                        // R11
    AST_REQ_ONLY_READY: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (link_ready && !busy));                          // R5
    AST_PIN_MOVE_BUSY: assert property (@(posedge clk) disable iff (rst)
        !$stable({xcvr_stb, xcvr_en}) |-> (busy && !link_ready));      // R4
    AST_FAIL_NOT_READY: assert property (@(posedge clk) disable iff (rst)
        init_fail |-> !link_ready);                                    // R7
    AST_STOP_TO_STANDBY: assert property (@(posedge clk) disable iff (rst)
        ctrl_stop |=> ##1 (!xcvr_stb && !xcvr_en));                    // R8
endmodule

bind xcvr_mode_seq xms_checker u_xms_chk (
    .clk        (clk),
    .rst        (rst),
    .req_ready  (req_ready),
    .ctrl_start (ctrl_start),
    .ctrl_stop  (ctrl_stop),
    .xcvr_stb   (xcvr_stb),
    .xcvr_en    (xcvr_en),
    .busy       (busy),
    .link_ready (link_ready),
    .init_fail  (init_fail)
);

// File: tb/tb_xcvr_mode_seq.sv
`timescale 1ns/1ps
module tb_xcvr_mode_seq;
    localparam int CLK_HZ = 8000;
    localparam int T      = CLK_HZ / 1000;
    localparam int PRE    = 1;
    localparam int SET    = 10;
    localparam int GAP    = 2;
    localparam int HOLD   = 50;
    localparam int BOI    = 100;
    localparam int TOL    = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic [1:0] req_mode = 2'd0;
    logic req_ready;
    logic init_start = 1'b0;
    logic bus_off = 1'b0;
    logic ctrl_start, ctrl_stop, xcvr_stb, xcvr_en;
    logic xcvr_fault_n = 1'b1;
    logic busy, link_ready, init_fail;

    always #4 clk = ~clk;

    xcvr_mode_seq #(
        .CLK_HZ(CLK_HZ), .PRE_SLEEP_MS(PRE), .SETTLE_MS(SET),
        .INIT_GAP_MS(GAP), .INIT_READY_MS(HOLD), .BUSOFF_IDLE_MS(BOI)
    ) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_mode(req_mode),
        .req_ready(req_ready), .init_start(init_start), .bus_off(bus_off),
        .ctrl_start(ctrl_start), .ctrl_stop(ctrl_stop), .xcvr_stb(xcvr_stb),
        .xcvr_en(xcvr_en), .xcvr_fault_n(xcvr_fault_n), .busy(busy),
        .link_ready(link_ready), .init_fail(init_fail)
    );

    int checks = 0;
    int errors = 0;
    bit done_flag = 1'b0;

    // event log at the ports
    int cyc = 0;
    logic [1:0] pins_prev = 2'b00;
    logic rdy_prev = 1'b0;
    int n_pin = 0, t_pin = 0;
    int n_start = 0, t_start = 0;
    int n_stop = 0, t_stop = 0;
    int n_rdy = 0, t_rdy = 0;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (!rst) begin
            if ({xcvr_stb, xcvr_en} != pins_prev) begin
                n_pin = n_pin + 1;
                t_pin = cyc;
            end
            if (ctrl_start) begin n_start = n_start + 1; t_start = cyc; end
            if (ctrl_stop)  begin n_stop  = n_stop + 1;  t_stop  = cyc; end
            if (link_ready && !rdy_prev) begin n_rdy = n_rdy + 1; t_rdy = cyc; end
        end
        pins_prev = {xcvr_stb, xcvr_en};
        rdy_prev  = link_ready;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_win(input string req, input int act, input int lo);
        check(act >= lo && act <= lo + TOL, req, act, lo);
    endtask

    function automatic int cur(input int sel);
        case (sel)
            0: return n_pin;
            1: return n_start;
            2: return n_stop;
            3: return n_rdy;
            default: return int'(init_fail);
        endcase
    endfunction

    task automatic wait_ev(input int sel, input int target, input string req);
        int guard = 0;
        while (cur(sel) < target && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        check(cur(sel) >= target, req, cur(sel), target);
    endtask

    task automatic pulse_init();
        @(negedge clk) init_start = 1'b1;
        @(negedge clk) init_start = 1'b0;
    endtask

    // vector: {mode code, expected stb, expected en}
    localparam logic [3:0] VEC [6] = '{
        {2'd2, 2'b10}, {2'd0, 2'b01}, {2'd1, 2'b00},
        {2'd3, 2'b11}, {2'd0, 2'b01}, {2'd2, 2'b10}
    };

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int p0, s0, r0, st0, tp_a, tp_b;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R2 reset state
        check({xcvr_stb, xcvr_en} == 2'b00, "R2 pins", {xcvr_stb, xcvr_en}, 0);
        check(!link_ready && !busy && !init_fail, "R2 status", {link_ready, busy, init_fail}, 0);
        check(!req_ready && !ctrl_start && !ctrl_stop, "R2 handshake", {req_ready, ctrl_start, ctrl_stop}, 0);

        // R5 request before init has no effect
        p0 = n_pin;
        req_mode = 2'd3; req_valid = 1'b1;
        repeat (20) @(negedge clk);
        check(!req_ready, "R5 ready before init", req_ready, 0);
        req_valid = 1'b0;
        @(negedge clk);
        check(n_pin == p0 && {xcvr_stb, xcvr_en} == 2'b00, "R5 pins untouched", {xcvr_stb, xcvr_en}, 0);

        // R6/R7 init with fault asserted
        xcvr_fault_n = 1'b0;
        p0 = n_pin; s0 = n_start;
        pulse_init();
        wait_ev(0, p0 + 1, "R6 sleep pins");
        check({xcvr_stb, xcvr_en} == 2'b01, "R6 sleep pair", {xcvr_stb, xcvr_en}, 1);
        tp_a = t_pin;
        wait_ev(1, s0 + 1, "R6 start pulse");
        check_win("R6 start delay", t_start - tp_a, (SET + GAP) * T);
        wait_ev(0, p0 + 2, "R6 normal pins");
        check({xcvr_stb, xcvr_en} == 2'b11, "R6 normal pair", {xcvr_stb, xcvr_en}, 3);
        check(t_pin - t_start >= 1 && t_pin - t_start <= TOL, "R6 normal after start", t_pin - t_start, 2);
        wait_ev(4, 1, "R7 init_fail");
        check(!link_ready && !busy, "R7 failed not ready", link_ready, 0);

        // R7 retry from failed state with fault clear
        xcvr_fault_n = 1'b1;
        p0 = n_pin; r0 = n_rdy;
        pulse_init();
        @(negedge clk);
        check(!init_fail, "R7 fail cleared on retry", init_fail, 0);
        wait_ev(0, p0 + 2, "R6 retry pins");
        tp_b = t_pin;
        wait_ev(3, r0 + 1, "R7 ready");
        check_win("R7 ready delay", t_rdy - tp_b, (SET + HOLD) * T);
        check(!init_fail && {xcvr_stb, xcvr_en} == 2'b11, "R7 operational", init_fail, 0);

        // table of mode requests: R1 pairs, R3 pre-wait, R4 settle
        for (int i = 0; i < 6; i++) begin
            int acc;
            p0 = n_pin; r0 = n_rdy;
            @(negedge clk);
            req_mode = VEC[i][3:2]; req_valid = 1'b1;
            #1;
            check(req_ready, "R5 ready when idle", req_ready, 1);
            acc = cyc + 1;
            @(negedge clk);
            req_valid = 1'b0;
            wait_ev(0, p0 + 1, "R1 pin change");
            check({xcvr_stb, xcvr_en} == VEC[i][1:0], "R1 pin pair", {xcvr_stb, xcvr_en}, VEC[i][1:0]);
            if (VEC[i][3:2] == 2'd0)
                check_win("R3 sleep pre-wait", t_pin - acc, PRE * T);
            else
                check_win("R3 no pre-wait", t_pin - acc, 0);
            tp_a = t_pin;
            wait_ev(3, r0 + 1, "R4 ready return");
            check_win("R4 settle", t_rdy - tp_a, SET * T);
        end

        // R8 bus-off recovery, with R5 requests offered while busy
        p0 = n_pin; s0 = n_start; st0 = n_stop; r0 = n_rdy;
        @(negedge clk) bus_off = 1'b1;
        @(negedge clk) bus_off = 1'b0;
        wait_ev(2, st0 + 1, "R8 stop pulse");
        req_mode = 2'd0; req_valid = 1'b1;
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            if (req_ready) check(1'b0, "R5 ready during busoff", 1, 0);
        end
        req_valid = 1'b0;
        wait_ev(0, p0 + 1, "R8 standby pins");
        check({xcvr_stb, xcvr_en} == 2'b00, "R8 standby pair", {xcvr_stb, xcvr_en}, 0);
        check(t_pin - t_stop >= 1 && t_pin - t_stop <= TOL, "R8 stop before standby", t_pin - t_stop, 2);
        tp_a = t_pin;
        wait_ev(0, p0 + 2, "R8 normal pins");
        check({xcvr_stb, xcvr_en} == 2'b11, "R8 normal pair", {xcvr_stb, xcvr_en}, 3);
        check_win("R8 bus idle gap", t_pin - tp_a, (SET + BOI) * T);
        tp_b = t_pin;
        wait_ev(1, s0 + 1, "R8 start pulse");
        check_win("R8 start after settle", t_start - tp_b, SET * T);
        wait_ev(3, r0 + 1, "R8 ready");
        check(n_pin == p0 + 2 && {xcvr_stb, xcvr_en} == 2'b11, "R5 busy request ignored", n_pin - p0, 2);

        // R9 bus_off and request in the same cycle
        p0 = n_pin; st0 = n_stop; r0 = n_rdy;
        @(negedge clk);
        req_mode = 2'd2; req_valid = 1'b1; bus_off = 1'b1;
        #1;
        check(!req_ready, "R9 request refused", req_ready, 0);
        @(negedge clk);
        req_valid = 1'b0; bus_off = 1'b0;
        wait_ev(2, st0 + 1, "R9 recovery runs");
        wait_ev(3, r0 + 1, "R9 ready again");
        check(n_pin == p0 + 2 && {xcvr_stb, xcvr_en} == 2'b11, "R9 no listen pins", {xcvr_stb, xcvr_en}, 3);
        check(!busy && link_ready, "R11 idle state", busy, 0);

        done_flag = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule